// File: doc/BRIEF.md
# AXI Minimum Response Latency Gate

This block sits on an AXI link between a master and a memory slave. It makes the memory look no faster than a chosen figure. Read data and write responses heading back to the master are held until a run-time programmable number of cycles has passed since their own transaction began. The latency settings are plain 12-bit configuration inputs, one for reads and one for writes.

A read starts in the first cycle its ARVALID is seen. A write starts in the first cycle the first WVALID of its burst is seen. Every accepted read address and every accepted first write beat stores its start cycle in a per-direction timestamp queue. Responses are matched to these timestamps in issue order, since the slave is assumed to complete in order. A response that the slave returns after its deadline is forwarded with only one register stage of delay. Address, write-data, ID and length fields pass through unchanged.

Both response channels are valid/ready streams. A beat is taken from the slave only when the gate's single-entry holding register is empty, or when that register is being emptied toward the master in the same cycle. While a beat waits for its deadline or for the master's ready, the slave-side ready stays low and the slave must hold its beat. Once a beat is shown to the master, it stays valid with a stable payload until the master accepts it. When a timestamp queue is full, new read addresses, or new first write beats, are stalled on both sides of the gate.

Top module: `axi_min_latency_gate`

## Requirements
- R1: The AR, AW and W fields (address, ID, length, data, strobe, last) reach the slave side unchanged in the same cycle.
- R2: If a read's ARVALID first rises in cycle c and the read latency is L, its first R beat is not valid toward the master before cycle c+L.
- R3: If a write burst's first WVALID rises in cycle c and the write latency is L, its B response is not valid toward the master before cycle c+L.
- R4: A response accepted from the slave in cycle d, after its deadline has already passed, is valid toward the master in cycle d+1.
- R5: After the first beat of a read burst has been released, the following beats of that burst do not wait for a deadline. With the slave presenting them back to back, they leave on consecutive cycles.
- R6: With a latency of 0, every response is valid toward the master exactly one cycle after the slave handshake.
- R7: While a held beat is valid toward the master and not accepted, its payload stays stable and the slave-side ready of that channel stays low.
- R8: Each direction tracks up to 16 open transactions. With 16 reads open, ARVALID is not passed on and ARREADY toward the master stays low. Both recover in the cycle after one read completes.
- R9: Each response is timed against the start cycle of its own transaction, taken in issue order, and not against the start cycle of any other outstanding transaction.
- R10: After reset, RVALID and BVALID toward the master are low, and RREADY and BREADY toward the slave are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_rd_lat | input | 12 | Minimum read latency in cycles |
| cfg_wr_lat | input | 12 | Minimum write latency in cycles |
| up_arvalid | input | 1 | Master read address valid |
| up_arready | output | 1 | Read address ready to master |
| up_araddr | input | ADDR_W | Master read address |
| up_arid | input | ID_W | Master read ID |
| up_arlen | input | 8 | Master read burst length |
| dn_arvalid | output | 1 | Read address valid to slave |
| dn_arready | input | 1 | Slave read address ready |
| dn_araddr | output | ADDR_W | Read address to slave |
| dn_arid | output | ID_W | Read ID to slave |
| dn_arlen | output | 8 | Read burst length to slave |
| up_awvalid | input | 1 | Master write address valid |
| up_awready | output | 1 | Write address ready to master |
| up_awaddr | input | ADDR_W | Master write address |
| up_awid | input | ID_W | Master write ID |
| up_awlen | input | 8 | Master write burst length |
| dn_awvalid | output | 1 | Write address valid to slave |
| dn_awready | input | 1 | Slave write address ready |
| dn_awaddr | output | ADDR_W | Write address to slave |
| dn_awid | output | ID_W | Write ID to slave |
| dn_awlen | output | 8 | Write burst length to slave |
| up_wvalid | input | 1 | Master write data valid |
| up_wready | output | 1 | Write data ready to master |
| up_wdata | input | DATA_W | Master write data |
| up_wstrb | input | DATA_W/8 | Master write strobes |
| up_wlast | input | 1 | Master last write beat |
| dn_wvalid | output | 1 | Write data valid to slave |
| dn_wready | input | 1 | Slave write data ready |
| dn_wdata | output | DATA_W | Write data to slave |
| dn_wstrb | output | DATA_W/8 | Write strobes to slave |
| dn_wlast | output | 1 | Last write beat to slave |
| dn_rvalid | input | 1 | Slave read data valid |
| dn_rready | output | 1 | Read data ready to slave |
| dn_rdata | input | DATA_W | Slave read data |
| dn_rid | input | ID_W | Slave read ID |
| dn_rresp | input | 2 | Slave read response |
| dn_rlast | input | 1 | Slave last read beat |
| up_rvalid | output | 1 | Read data valid to master |
| up_rready | input | 1 | Master read data ready |
| up_rdata | output | DATA_W | Read data to master |
| up_rid | output | ID_W | Read ID to master |
| up_rresp | output | 2 | Read response to master |
| up_rlast | output | 1 | Last read beat to master |
| dn_bvalid | input | 1 | Slave write response valid |
| dn_bready | output | 1 | Write response ready to slave |
| dn_bid | input | ID_W | Slave write response ID |
| dn_bresp | input | 2 | Slave write response code |
| up_bvalid | output | 1 | Write response valid to master |
| up_bready | input | 1 | Master write response ready |
| up_bid | output | ID_W | Write response ID to master |
| up_bresp | output | 2 | Write response code to master |

## Verification
A table of read and write transactions varies the latency setting against the slave's own response delay. Some rows have the slave respond well before the deadline, which shows that the gate holds the response. Other rows have it respond after the deadline, which shows that nothing beyond one register stage is added. Rows with zero latency and multi-beat bursts cover the registered pass-through and the free passage of trailing beats. Directed runs then cover:
- two reads issued five cycles apart, whose release times differ only if each read carries its own timestamp;
- a master that withholds ready, which exposes whether the held beat stays stable and the slave is stalled;
- sixteen open reads, which shows the address stall and its release after one completion.

// File: rtl/lat_gate_pkg.sv
package lat_gate_pkg;
  localparam int unsigned LAT_W = 12;
  localparam int unsigned TS_W  = 16;
  typedef logic [LAT_W-1:0] lat_t;
  typedef logic [TS_W-1:0]  ts_t;
endpackage

// File: rtl/lat_start_stamp.sv
module lat_start_stamp
  import lat_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ts_t  now,
  input  logic req_valid,
  input  logic req_fire,
  output ts_t  stamp
);
  logic waiting;
  ts_t  held;

  assign stamp = waiting ? held : now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting <= 1'b0;
      held    <= '0;
    end else if (req_fire) begin
      waiting <= 1'b0;
    end else if (req_valid && !waiting) begin
      waiting <= 1'b1;
      held    <= now;
    end
  end

  // R2/R3: a stalled request keeps the cycle it first appeared in
  p_stamp_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_fire) |=> $stable(stamp));
endmodule

// File: rtl/lat_ts_fifo.sv
module lat_ts_fifo
  import lat_gate_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  ts_t  push_ts,
  input  logic pop,
  output ts_t  head_ts,
  output logic empty,
  output logic full
);
  localparam int unsigned PW = $clog2(DEPTH);

  ts_t         mem [DEPTH];
  logic [PW:0] wr_p, rd_p;

  assign empty   = (wr_p == rd_p);
  assign full    = (wr_p[PW] != rd_p[PW]) && (wr_p[PW-1:0] == rd_p[PW-1:0]);
  assign head_ts = mem[rd_p[PW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_p <= '0;
      rd_p <= '0;
    end else begin
      if (push) wr_p <= wr_p + 1'b1;
      if (pop)  rd_p <= rd_p + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_p[PW-1:0]] <= push_ts;
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
endmodule

// File: rtl/lat_resp_gate.sv
module lat_resp_gate
  import lat_gate_pkg::*;
#(
  parameter int unsigned PAY_W = 38
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ts_t              now,
  input  lat_t             lat,
  input  ts_t              head_ts,
  input  logic             head_valid,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAY_W-1:0] in_pay,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_pay,
  output logic             out_last,
  output logic             pop
);
  logic             buf_v, buf_last, burst_open, due, fire;
  logic [PAY_W-1:0] buf_pay;
  ts_t              elapsed;

  assign elapsed   = now - head_ts;
  assign due       = head_valid && (burst_open || (elapsed >= ts_t'(lat)));
  assign out_valid = buf_v && due;
  assign out_pay   = buf_pay;
  assign out_last  = buf_last;
  assign fire      = out_valid && out_ready;
  assign in_ready  = !buf_v || fire;
  assign pop       = fire && buf_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_v      <= 1'b0;
      buf_last   <= 1'b0;
      buf_pay    <= '0;
      burst_open <= 1'b0;
    end else begin
      if (in_valid && in_ready) begin
        buf_v    <= 1'b1;
        buf_pay  <= in_pay;
        buf_last <= in_last;
      end else if (fire) begin
        buf_v <= 1'b0;
      end
      if (fire) burst_open <= !buf_last;
    end
  end

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pay)));
  p_stall_slave_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  p_pop_matched_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_valid);
endmodule

// File: rtl/axi_min_latency_gate.sv
module axi_min_latency_gate
  import lat_gate_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ID_W    = 4,
  parameter int unsigned Q_DEPTH = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [11:0]         cfg_rd_lat,
  input  logic [11:0]         cfg_wr_lat,
  input  logic                up_arvalid,
  output logic                up_arready,
  input  logic [ADDR_W-1:0]   up_araddr,
  input  logic [ID_W-1:0]     up_arid,
  input  logic [7:0]          up_arlen,
  output logic                dn_arvalid,
  input  logic                dn_arready,
  output logic [ADDR_W-1:0]   dn_araddr,
  output logic [ID_W-1:0]     dn_arid,
  output logic [7:0]          dn_arlen,
  input  logic                up_awvalid,
  output logic                up_awready,
  input  logic [ADDR_W-1:0]   up_awaddr,
  input  logic [ID_W-1:0]     up_awid,
  input  logic [7:0]          up_awlen,
  output logic                dn_awvalid,
  input  logic                dn_awready,
  output logic [ADDR_W-1:0]   dn_awaddr,
  output logic [ID_W-1:0]     dn_awid,
  output logic [7:0]          dn_awlen,
  input  logic                up_wvalid,
  output logic                up_wready,
  input  logic [DATA_W-1:0]   up_wdata,
  input  logic [DATA_W/8-1:0] up_wstrb,
  input  logic                up_wlast,
  output logic                dn_wvalid,
  input  logic                dn_wready,
  output logic [DATA_W-1:0]   dn_wdata,
  output logic [DATA_W/8-1:0] dn_wstrb,
  output logic                dn_wlast,
  input  logic                dn_rvalid,
  output logic                dn_rready,
  input  logic [DATA_W-1:0]   dn_rdata,
  input  logic [ID_W-1:0]     dn_rid,
  input  logic [1:0]          dn_rresp,
  input  logic                dn_rlast,
  output logic                up_rvalid,
  input  logic                up_rready,
  output logic [DATA_W-1:0]   up_rdata,
  output logic [ID_W-1:0]     up_rid,
  output logic [1:0]          up_rresp,
  output logic                up_rlast,
  input  logic                dn_bvalid,
  output logic                dn_bready,
  input  logic [ID_W-1:0]     dn_bid,
  input  logic [1:0]          dn_bresp,
  output logic                up_bvalid,
  input  logic                up_bready,
  output logic [ID_W-1:0]     up_bid,
  output logic [1:0]          up_bresp
);
  localparam int unsigned RPAY_W = ID_W + 2 + DATA_W;
  localparam int unsigned BPAY_W = ID_W + 2;

  ts_t  now_q, rd_stamp, wr_stamp, rd_head, wr_head;
  logic rd_full, rd_empty, wr_full, wr_empty, rd_pop, wr_pop;
  logic ar_fire, w_fire, w_first, w_block, bpay_last;
  logic [RPAY_W-1:0] rpay;
  logic [BPAY_W-1:0] bpay;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= now_q + 1'b1;
  end

  // Read address: pass-through, stalled while the read queue is full
  assign dn_arvalid = up_arvalid && !rd_full;
  assign up_arready = dn_arready && !rd_full;
  assign dn_araddr  = up_araddr;
  assign dn_arid    = up_arid;
  assign dn_arlen   = up_arlen;
  assign ar_fire    = up_arvalid && up_arready;

  // Write address: plain pass-through
  assign dn_awvalid = up_awvalid;
  assign up_awready = dn_awready;
  assign dn_awaddr  = up_awaddr;
  assign dn_awid    = up_awid;
  assign dn_awlen   = up_awlen;

  // Write data: first beat of a burst opens a write transaction
  assign w_block   = w_first && wr_full;
  assign dn_wvalid = up_wvalid && !w_block;
  assign up_wready = dn_wready && !w_block;
  assign dn_wdata  = up_wdata;
  assign dn_wstrb  = up_wstrb;
  assign dn_wlast  = up_wlast;
  assign w_fire    = up_wvalid && up_wready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      w_first <= 1'b1;
    else if (w_fire) w_first <= up_wlast;
  end

  lat_start_stamp u_rd_stamp (
    .clk(clk), .rst_n(rst_n), .now(now_q),
    .req_valid(up_arvalid), .req_fire(ar_fire), .stamp(rd_stamp));

  lat_start_stamp u_wr_stamp (
    .clk(clk), .rst_n(rst_n), .now(now_q),
    .req_valid(up_wvalid && w_first), .req_fire(w_fire && w_first), .stamp(wr_stamp));

  lat_ts_fifo #(.DEPTH(Q_DEPTH)) u_rd_q (
    .clk(clk), .rst_n(rst_n), .push(ar_fire), .push_ts(rd_stamp),
    .pop(rd_pop), .head_ts(rd_head), .empty(rd_empty), .full(rd_full));

  lat_ts_fifo #(.DEPTH(Q_DEPTH)) u_wr_q (
    .clk(clk), .rst_n(rst_n), .push(w_fire && w_first), .push_ts(wr_stamp),
    .pop(wr_pop), .head_ts(wr_head), .empty(wr_empty), .full(wr_full));

  lat_resp_gate #(.PAY_W(RPAY_W)) u_r_gate (
    .clk(clk), .rst_n(rst_n), .now(now_q), .lat(cfg_rd_lat),
    .head_ts(rd_head), .head_valid(!rd_empty),
    .in_valid(dn_rvalid), .in_ready(dn_rready),
    .in_pay({dn_rid, dn_rresp, dn_rdata}), .in_last(dn_rlast),
    .out_valid(up_rvalid), .out_ready(up_rready),
    .out_pay(rpay), .out_last(up_rlast), .pop(rd_pop));

  lat_resp_gate #(.PAY_W(BPAY_W)) u_b_gate (
    .clk(clk), .rst_n(rst_n), .now(now_q), .lat(cfg_wr_lat),
    .head_ts(wr_head), .head_valid(!wr_empty),
    .in_valid(dn_bvalid), .in_ready(dn_bready),
    .in_pay({dn_bid, dn_bresp}), .in_last(1'b1),
    .out_valid(up_bvalid), .out_ready(up_bready),
    .out_pay(bpay), .out_last(bpay_last), .pop(wr_pop));

  assign {up_rid, up_rresp, up_rdata} = rpay;
  assign {up_bid, up_bresp}           = bpay;

  p_ar_stall_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_full |-> (!dn_arvalid && !up_arready));
  p_b_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    up_bvalid |-> bpay_last);
endmodule

// File: tb/sim_axi_min_latency_gate.sv
module sim_axi_min_latency_gate;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] cfg_rd_lat = '0, cfg_wr_lat = '0;
  logic up_arvalid = 0, dn_arready = 0, up_awvalid = 0, dn_awready = 0;
  logic [31:0] up_araddr = '0, up_awaddr = '0, up_wdata = '0, dn_rdata = '0;
  logic [3:0] up_arid = '0, up_awid = '0, dn_rid = '0, dn_bid = '0, up_wstrb = '0;
  logic [7:0] up_arlen = '0, up_awlen = '0;
  logic up_wvalid = 0, up_wlast = 0, dn_wready = 0;
  logic dn_rvalid = 0, dn_rlast = 0, up_rready = 1, dn_bvalid = 0, up_bready = 1;
  logic [1:0] dn_rresp = '0, dn_bresp = '0;
  logic up_arready, dn_arvalid, up_awready, dn_awvalid, up_wready, dn_wvalid, dn_wlast;
  logic [31:0] dn_araddr, dn_awaddr, dn_wdata, up_rdata;
  logic [3:0] dn_arid, dn_awid, dn_wstrb, up_rid, up_bid;
  logic [7:0] dn_arlen, dn_awlen;
  logic dn_rready, up_rvalid, up_rlast, dn_bready, up_bvalid;
  logic [1:0] up_rresp, up_bresp;

  axi_min_latency_gate u0 (.*);

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int r_n = 0, b_n = 0;
  int r_t [256];
  logic [31:0] r_d [256];
  logic r_l [256];
  int b_t [256];
  logic [3:0] b_id [256];

  always @(negedge clk) begin
    #2;
    if (up_rvalid && up_rready) begin
      r_t[r_n] = cyc; r_d[r_n] = up_rdata; r_l[r_n] = up_rlast; r_n++;
    end
    if (up_bvalid && up_bready) begin
      b_t[b_n] = cyc; b_id[b_n] = up_bid; b_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic wait_rn(input int n);
    int k = 0;
    while (r_n < n && k < 400) begin @(negedge clk); #3; k++; end
    @(negedge clk);
  endtask

  task automatic wait_bn(input int n);
    int k = 0;
    while (b_n < n && k < 400) begin @(negedge clk); #3; k++; end
    @(negedge clk);
  endtask

  // Present one beat and hold it until the gate takes it; returns at a falling edge
  task automatic slave_r(input logic [31:0] d, input logic last, input logic [3:0] id);
    dn_rvalid = 1; dn_rdata = d; dn_rlast = last; dn_rid = id;
    #1;
    while (!dn_rready) begin @(negedge clk); #1; end
    @(negedge clk);
    dn_rvalid = 0; dn_rlast = 0;
  endtask

  task automatic slave_b(input logic [3:0] id);
    dn_bvalid = 1; dn_bid = id;
    #1;
    while (!dn_bready) begin @(negedge clk); #1; end
    @(negedge clk);
    dn_bvalid = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // Vector: [31] write, [27:16] latency, [15:8] slave delay after start, [3:0] beats
  localparam logic [31:0] VEC [9] = '{
    {1'b0, 3'd0, 12'd20, 8'd2,  8'd1},
    {1'b0, 3'd0, 12'd3,  8'd10, 8'd1},
    {1'b0, 3'd0, 12'd0,  8'd3,  8'd1},
    {1'b0, 3'd0, 12'd12, 8'd1,  8'd4},
    {1'b0, 3'd0, 12'd1,  8'd6,  8'd3},
    {1'b1, 3'd0, 12'd25, 8'd2,  8'd1},
    {1'b1, 3'd0, 12'd4,  8'd9,  8'd3},
    {1'b1, 3'd0, 12'd0,  8'd1,  8'd1},
    {1'b1, 3'd0, 12'd10, 8'd4,  8'd4}
  };

  function automatic string tag_of(input bit wr, input int lat, input int dly, input int nb);
    if (lat == 0) return "R6 zero latency";
    if (dly + 1 > lat) return "R4 late response";
    if (nb > 1 && !wr) return "R5 burst after deadline";
    return wr ? "R3 write minimum" : "R2 read minimum";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    dn_arready = 1; dn_awready = 1; dn_wready = 1;
    do_reset();
    #1;
    // R10 reset state
    chk(up_rvalid == 0, "R10 rvalid after reset", up_rvalid, 0);
    chk(up_bvalid == 0, "R10 bvalid after reset", up_bvalid, 0);
    chk(dn_rready == 1 && dn_bready == 1, "R10 slave readies", {dn_rready, dn_bready}, 3);

    // R1 pass-through of request fields
    @(negedge clk);
    up_araddr = 32'hA5A5_0010; up_arid = 4'd5; up_arlen = 8'd3;
    up_awaddr = 32'h0BAD_F00C; up_awlen = 8'd7; up_wdata = 32'h1234_5678; up_wstrb = 4'hA;
    #1;
    chk(dn_araddr == 32'hA5A5_0010 && dn_arid == 4'd5 && dn_arlen == 8'd3,
        "R1 AR fields", dn_araddr, 32'hA5A5_0010);
    chk(dn_awaddr == 32'h0BAD_F00C && dn_awlen == 8'd7, "R1 AW fields", dn_awaddr, 32'h0BAD_F00C);
    chk(dn_wdata == 32'h1234_5678 && dn_wstrb == 4'hA, "R1 W fields", dn_wdata, 32'h1234_5678);
    @(negedge clk);

    // Table walk
    for (int i = 0; i < 9; i++) begin
      logic [31:0] v;
      int lat, dly, nb, c, exp0, base;
      bit wr;
      string tg;
      v = VEC[i];
      wr = v[31]; lat = int'(v[27:16]); dly = int'(v[15:8]); nb = int'(v[3:0]);
      exp0 = (dly + 1 > lat) ? dly + 1 : lat;
      tg = tag_of(wr, lat, dly, nb);
      cfg_rd_lat = 12'(lat); cfg_wr_lat = 12'(lat);
      @(negedge clk);
      if (!wr) begin
        base = r_n; c = cyc;
        up_arvalid = 1;
        @(negedge clk);
        up_arvalid = 0;
        wait_until(c + dly);
        for (int b = 0; b < nb; b++)
          slave_r(32'h100 * i + b, b == nb - 1, 4'(i));
        wait_rn(base + nb);
        for (int b = 0; b < nb; b++) begin
          chk(r_t[base + b] - c == exp0 + b, tg, r_t[base + b] - c, exp0 + b);
          chk(r_d[base + b] == 32'h100 * i + b && r_l[base + b] == (b == nb - 1),
              "R1 read payload", r_d[base + b], 32'h100 * i + b);
        end
      end else begin
        base = b_n; c = cyc;
        up_awvalid = 1;
        for (int b = 0; b < nb; b++) begin
          up_wvalid = 1; up_wlast = (b == nb - 1);
          @(negedge clk);
          up_awvalid = 0;
        end
        up_wvalid = 0; up_wlast = 0;
        wait_until(c + dly);
        slave_b(4'(i));
        wait_bn(base + 1);
        chk(b_t[base] - c == exp0, tg, b_t[base] - c, exp0);
        chk(b_id[base] == 4'(i), "R1 write response id", b_id[base], i);
      end
    end

    // R9: two reads five cycles apart, each timed from its own start
    begin
      int c, base;
      cfg_rd_lat = 12'd15;
      @(negedge clk);
      base = r_n; c = cyc;
      up_arvalid = 1; @(negedge clk); up_arvalid = 0;
      wait_until(c + 5);
      up_arvalid = 1; @(negedge clk); up_arvalid = 0;
      slave_r(32'hAAAA_0001, 1, 4'd1);
      slave_r(32'hAAAA_0002, 1, 4'd2);
      wait_rn(base + 2);
      chk(r_t[base] - c == 15, "R9 first read timing", r_t[base] - c, 15);
      chk(r_t[base + 1] - c == 20, "R9 second read own stamp", r_t[base + 1] - c, 20);
      chk(r_d[base + 1] == 32'hAAAA_0002, "R9 order", r_d[base + 1], 32'hAAAA_0002);
    end

    // R7: master withholds ready on a two-beat burst
    begin
      int base;
      cfg_rd_lat = 12'd0;
      up_rready = 0;
      @(negedge clk);
      base = r_n;
      up_arvalid = 1; @(negedge clk); up_arvalid = 0;
      fork
        begin
          slave_r(32'hBEEF_0000, 0, 4'd3);
          slave_r(32'hBEEF_0001, 1, 4'd3);
        end
        begin
          repeat (3) @(negedge clk);
          #1;
          chk(up_rvalid == 1 && up_rdata == 32'hBEEF_0000, "R7 held beat stable",
              up_rdata, 32'hBEEF_0000);
          chk(dn_rready == 0, "R7 slave stalled", dn_rready, 0);
          @(negedge clk);
          up_rready = 1;
        end
      join
      wait_rn(base + 2);
      chk(r_d[base] == 32'hBEEF_0000 && r_d[base + 1] == 32'hBEEF_0001,
          "R7 both beats delivered", r_d[base + 1], 32'hBEEF_0001);
    end

    // R8: sixteen open reads stall the seventeenth
    begin
      int c;
      cfg_rd_lat = 12'd0;
      @(negedge clk);
      c = cyc;
      up_arvalid = 1;
      wait_until(c + 16);
      #1;
      chk(up_arready == 0 && dn_arvalid == 0, "R8 full queue stalls AR",
          {up_arready, dn_arvalid}, 0);
      slave_r(32'hC0DE_0000, 1, 4'd0);   // accepted end of c+16, out c+17
      wait_until(c + 18);
      #1;
      chk(up_arready == 1 && dn_arvalid == 1, "R8 AR resumes after completion",
          {up_arready, dn_arvalid}, 3);
      @(negedge clk);
      up_arvalid = 0;
      do_reset();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule